// File: doc/BRIEF.md
# Function State and Event Queue Controller

This block keeps the configuration state of a small set of device functions and reports changes of that state to a host through an ordered queue of event records. Each function sits in a numbered slot. It is known to commands by a function identifier and to events by a handle. A function is brought into the set by a hot-plug request and leaves it by a hot-unplug request. Single-cycle commands then walk it through the reserved, standby, disabled, enabled and error states. Every command gets a response code one cycle later.

Events come from hot-plug, hot-unplug, translation faults and the expiry of a per-function release timer. They are appended to a first-in first-out queue. The host sees the oldest record on the event outputs while the pending flag is high, and removes it with a one-cycle pop. A strobe marks every record that is accepted, so the host knows to come and read. A hot-unplug of a function that is still in use does not remove it at once. It raises a detach request and starts a countdown of a programmable number of ticks. If the function has not been deconfigured to standby by the end of the countdown, it is removed by force.

Top module: `fn_state_evq`

## Requirements
- R1: Configure (cmd_op 0) returns 4 for an identifier that no present function holds, 3 for a reserved function, 1 for a standby function (which becomes disabled), and 2 for any other state, leaving that state unchanged.
- R2: Deconfigure (cmd_op 1) returns 4 for an unknown identifier, 3 for a reserved function and 2 for a standby function. In any other state it returns 1, moves the function to standby, clears its handle enable bit and cancels a running release timer.
- R3: Enable (cmd_op 2) returns 1 and moves a disabled function to enabled with its handle enable bit set. It returns 3 for a reserved function, 4 for an unknown identifier and 2 otherwise. Function reset (cmd_op 3) returns 2 on a reserved or standby function. In any other state it returns 1, clears the handle enable bit and moves the function to disabled. The enable bit is only ever set in the enabled or error state.
- R4: rsp_valid is high for exactly the one cycle after a command is accepted, with rsp_code valid in that cycle.
- R5: A hot-plug into an empty slot makes the function present with plug_fid. It enters reserved silently if plug_attach is 0. If plug_attach is 1 it enters standby and queues an availability record with status 16'h0301. A plug with plug_attach 1 into a reserved slot also moves it to standby with that record. A plug whose identifier is held by another present function, or that hits any other state, is ignored.
- R6: A hot-unplug removes a reserved function silently. It removes a standby function and queues status 16'h0308. In any other state it queues a detach request with status 16'h0303 and loads the release timer with rel_ticks, unless that timer is already running.
- R7: A running release timer counts down on each cycle with tmr_tick high. In the cycle after it reaches zero, the function is forced to standby and removed, and an availability record with status 16'h0304 is queued.
- R8: A translation fault on an enabled function moves it to the error state and queues an error record carrying fault_code, fault_addr and fault_info. A fault in any other state is ignored.
- R9: A record has type 1 for an error and 2 for availability. Its handle has the enable bit at bit 31 and the slot number in the low SLOT_W bits, with zeros elsewhere. Availability records carry zero address and extra word.
- R10: Records leave the queue in the order they entered. evt_pending is high while the queue holds a record, the outputs show the oldest record, and a pop removes it.
- R11: crw_strobe is high for one cycle after every accepted record, and not for a dropped one.
- R12: A record that arrives while the queue holds 16 records is dropped and sets evt_overflow, which stays set until reset.
- R13: Only one request is served per cycle, in the priority order timer expiry, fault, unplug, plug, command. Lower requests in that cycle are discarded, and a discarded command gets no response.
- R14: After reset no function is present, the queue is empty, and rsp_valid, crw_strobe and evt_overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 configure, 1 deconfigure, 2 enable, 3 function reset |
| cmd_fid | input | FID_W | Function identifier addressed by the command |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 3 | 1 done, 2 no action, 3 reserved, 4 not recognized |
| plug_valid | input | 1 | Hot-plug request |
| plug_slot | input | SLOT_W | Slot to plug |
| plug_fid | input | FID_W | Identifier for a newly plugged function |
| plug_attach | input | 1 | Bring the function to standby |
| unplug_valid | input | 1 | Hot-unplug request |
| unplug_slot | input | SLOT_W | Slot to unplug |
| rel_ticks | input | TMR_W | Release timer load value |
| tmr_tick | input | 1 | Timer tick |
| fault_valid | input | 1 | Translation fault notification |
| fault_slot | input | SLOT_W | Faulting function slot |
| fault_code | input | 16 | Fault status code |
| fault_addr | input | ADDR_W | Faulting address |
| fault_info | input | 32 | Extra fault word |
| evt_pending | output | 1 | Queue not empty |
| evt_pop | input | 1 | Remove the oldest record |
| evt_type | output | 2 | Record type of the oldest record |
| evt_handle | output | 32 | Function handle |
| evt_fid | output | FID_W | Function identifier |
| evt_status | output | 16 | Status code |
| evt_addr | output | ADDR_W | Fault address |
| evt_extra | output | 32 | Extra word |
| evt_overflow | output | 1 | Sticky record-dropped flag |
| crw_strobe | output | 1 | Record accepted pulse |

## Verification
Every request is registered at the edge that samples it. The response, the new function state, the queued record and the strobe are therefore all visible in the cycle after that edge. The bench drives each request for one cycle just after an edge and samples one time unit after the next edge. Head-of-queue fields are read before the pop that retires them. For the release timer, a countdown loaded with N and ticked every cycle reaches zero after N ticking edges and acts at edge N+1. The bench checks that no record is present after N edges and that the forced record is present after N+1.

// File: rtl/fn_state_evq.sv
module fn_state_evq #(
  parameter int SLOT_W = 2,
  parameter int FID_W  = 8,
  parameter int ADDR_W = 32,
  parameter int TMR_W  = 16,
  parameter int Q_AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [FID_W-1:0]  cmd_fid,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  input  logic              plug_valid,
  input  logic [SLOT_W-1:0] plug_slot,
  input  logic [FID_W-1:0]  plug_fid,
  input  logic              plug_attach,
  input  logic              unplug_valid,
  input  logic [SLOT_W-1:0] unplug_slot,
  input  logic [TMR_W-1:0]  rel_ticks,
  input  logic              tmr_tick,
  input  logic              fault_valid,
  input  logic [SLOT_W-1:0] fault_slot,
  input  logic [15:0]       fault_code,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [31:0]       fault_info,
  output logic              evt_pending,
  input  logic              evt_pop,
  output logic [1:0]        evt_type,
  output logic [31:0]       evt_handle,
  output logic [FID_W-1:0]  evt_fid,
  output logic [15:0]       evt_status,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [31:0]       evt_extra,
  output logic              evt_overflow,
  output logic              crw_strobe
);
  localparam int NFUNC  = 1 << SLOT_W;
  localparam int QDEPTH = 1 << Q_AW;
  localparam int RW     = 2 + 32 + FID_W + 16 + ADDR_W + 32;
  localparam logic [Q_AW:0] QFULL = QDEPTH[Q_AW:0];

  localparam logic [2:0] ST_RSV = 3'd0, ST_STBY = 3'd1, ST_DIS = 3'd2,
                         ST_ENA = 3'd3, ST_ERR = 3'd4;
  localparam logic [2:0] RSP_DONE = 3'd1, RSP_NOACT = 3'd2,
                         RSP_RSV = 3'd3, RSP_UNK = 3'd4;
  localparam logic [1:0] OP_CFG = 2'd0, OP_DCFG = 2'd1, OP_ENA = 2'd2;
  localparam logic [1:0] EV_ERR = 2'd1, EV_AVL = 2'd2;
  localparam logic [15:0] PS_ATTACH = 16'h0301, PS_DETREQ = 16'h0303,
                          PS_FORCED = 16'h0304, PS_REMOVED = 16'h0308;

  logic [NFUNC-1:0] pres_q, hen_q, tmr_on;
  logic [2:0]       st_q    [NFUNC];
  logic [FID_W-1:0] fid_q   [NFUNC];
  logic [TMR_W-1:0] tmr_cnt [NFUNC];
  logic [3*NFUNC-1:0] st_flat;

  logic [NFUNC-1:0]  c_hit, p_dup, x_vec;
  logic [SLOT_W-1:0] c_idx, x_idx;
  logic c_found, x_any, f_go, u_go, p_go, c_go;

  always_comb begin
    c_idx = '0;
    x_idx = '0;
    for (int i = NFUNC - 1; i >= 0; i--) begin
      c_hit[i] = pres_q[i] && (fid_q[i] == cmd_fid);
      p_dup[i] = pres_q[i] && (fid_q[i] == plug_fid) && (SLOT_W'(i) != plug_slot);
      x_vec[i] = tmr_on[i] && (tmr_cnt[i] == '0);
      if (c_hit[i]) c_idx = SLOT_W'(i);
      if (x_vec[i]) x_idx = SLOT_W'(i);
    end
  end

  assign c_found = |c_hit;
  assign x_any   = |x_vec;
  assign f_go    = fault_valid && !x_any;
  assign u_go    = unplug_valid && !x_any && !fault_valid;
  assign p_go    = plug_valid && !x_any && !fault_valid && !unplug_valid;
  assign c_go    = cmd_valid && !(x_any || fault_valid || unplug_valid || plug_valid);

  logic [2:0] c_st, c_nst, c_rsp;
  logic       c_upd, c_en;
  assign c_st = st_q[c_idx];

  always_comb begin
    c_rsp = RSP_NOACT;
    c_nst = c_st;
    c_en  = hen_q[c_idx];
    c_upd = 1'b0;
    if (!c_found) c_rsp = RSP_UNK;
    else case (cmd_op)
      OP_CFG:
        if (c_st == ST_RSV) c_rsp = RSP_RSV;
        else if (c_st == ST_STBY) begin
          c_rsp = RSP_DONE; c_nst = ST_DIS; c_upd = 1'b1;
        end
      OP_DCFG:
        if (c_st == ST_RSV) c_rsp = RSP_RSV;
        else if (c_st != ST_STBY) begin
          c_rsp = RSP_DONE; c_nst = ST_STBY; c_en = 1'b0; c_upd = 1'b1;
        end
      OP_ENA:
        if (c_st == ST_RSV) c_rsp = RSP_RSV;
        else if (c_st == ST_DIS) begin
          c_rsp = RSP_DONE; c_nst = ST_ENA; c_en = 1'b1; c_upd = 1'b1;
        end
      default:
        if (c_st != ST_RSV && c_st != ST_STBY) begin
          c_rsp = RSP_DONE; c_nst = ST_DIS; c_en = 1'b0; c_upd = 1'b1;
        end
    endcase
  end

  logic p_new, p_att, f_ok;
  assign p_new = !pres_q[plug_slot] && !(|p_dup);
  assign p_att = pres_q[plug_slot] && (st_q[plug_slot] == ST_RSV) && plug_attach;
  assign f_ok  = pres_q[fault_slot] && (st_q[fault_slot] == ST_ENA);

  logic              ev_push;
  logic [1:0]        ev_type;
  logic [SLOT_W-1:0] ev_slot;
  logic [FID_W-1:0]  ev_fid;
  logic [15:0]       ev_stat;
  logic [ADDR_W-1:0] ev_addr;
  logic [31:0]       ev_xtra, ev_hnd;

  always_comb begin
    ev_push = 1'b0; ev_type = EV_AVL; ev_slot = '0; ev_stat = '0;
    ev_addr = '0;   ev_xtra = '0;
    if (x_any) begin
      ev_push = 1'b1; ev_slot = x_idx; ev_stat = PS_FORCED;
    end else if (fault_valid) begin
      ev_slot = fault_slot;
      if (f_ok) begin
        ev_push = 1'b1; ev_type = EV_ERR; ev_stat = fault_code;
        ev_addr = fault_addr; ev_xtra = fault_info;
      end
    end else if (unplug_valid) begin
      ev_slot = unplug_slot;
      if (pres_q[unplug_slot]) begin
        if (st_q[unplug_slot] == ST_STBY) begin
          ev_push = 1'b1; ev_stat = PS_REMOVED;
        end else if (st_q[unplug_slot] != ST_RSV && !tmr_on[unplug_slot]) begin
          ev_push = 1'b1; ev_stat = PS_DETREQ;
        end
      end
    end else if (plug_valid) begin
      ev_slot = plug_slot;
      if ((p_new && plug_attach) || p_att) begin
        ev_push = 1'b1; ev_stat = PS_ATTACH;
      end
    end
    ev_fid = pres_q[ev_slot] ? fid_q[ev_slot] : plug_fid;
    ev_hnd = {hen_q[ev_slot], {(31 - SLOT_W){1'b0}}, ev_slot};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      pres_q    <= '0;
      hen_q     <= '0;
      tmr_on    <= '0;
      for (int i = 0; i < NFUNC; i++) begin
        st_q[i]    <= ST_RSV;
        fid_q[i]   <= '0;
        tmr_cnt[i] <= '0;
      end
    end else begin
      rsp_valid <= c_go;
      if (c_go) rsp_code <= c_rsp;
      for (int i = 0; i < NFUNC; i++)
        if (tmr_on[i] && tmr_tick && tmr_cnt[i] != '0) tmr_cnt[i] <= tmr_cnt[i] - 1'b1;
      if (x_any) begin
        st_q[x_idx]   <= ST_STBY;
        pres_q[x_idx] <= 1'b0;
        hen_q[x_idx]  <= 1'b0;
        tmr_on[x_idx] <= 1'b0;
      end else if (f_go) begin
        if (f_ok) st_q[fault_slot] <= ST_ERR;
      end else if (u_go) begin
        if (pres_q[unplug_slot]) begin
          if (st_q[unplug_slot] == ST_RSV || st_q[unplug_slot] == ST_STBY)
            pres_q[unplug_slot] <= 1'b0;
          else if (!tmr_on[unplug_slot]) begin
            tmr_on[unplug_slot]  <= 1'b1;
            tmr_cnt[unplug_slot] <= rel_ticks;
          end
        end
      end else if (p_go) begin
        if (p_new) begin
          pres_q[plug_slot] <= 1'b1;
          fid_q[plug_slot]  <= plug_fid;
          st_q[plug_slot]   <= plug_attach ? ST_STBY : ST_RSV;
          hen_q[plug_slot]  <= 1'b0;
          tmr_on[plug_slot] <= 1'b0;
        end else if (p_att) st_q[plug_slot] <= ST_STBY;
      end else if (c_go && c_upd) begin
        st_q[c_idx]  <= c_nst;
        hen_q[c_idx] <= c_en;
        if (c_nst == ST_STBY) tmr_on[c_idx] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NFUNC; g++) begin : g_flat
    assign st_flat[3*g +: 3] = st_q[g];
  end

  logic [RW-1:0]   q_mem [QDEPTH];
  logic [Q_AW-1:0] q_wp, q_rp;
  logic [Q_AW:0]   q_cnt;
  logic            push_ok, pop_ok;

  assign push_ok     = ev_push && (q_cnt != QFULL);
  assign pop_ok      = evt_pop && (q_cnt != '0);
  assign evt_pending = (q_cnt != '0);
  assign {evt_type, evt_handle, evt_fid, evt_status, evt_addr, evt_extra} = q_mem[q_rp];

  always_ff @(posedge clk)
    if (push_ok) q_mem[q_wp] <= {ev_type, ev_hnd, ev_fid, ev_stat, ev_addr, ev_xtra};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wp <= '0; q_rp <= '0; q_cnt <= '0;
      evt_overflow <= 1'b0;
      crw_strobe   <= 1'b0;
    end else begin
      if (push_ok) q_wp <= q_wp + 1'b1;
      if (pop_ok)  q_rp <= q_rp + 1'b1;
      q_cnt <= q_cnt + (Q_AW+1)'(push_ok) - (Q_AW+1)'(pop_ok);
      if (ev_push && !push_ok) evt_overflow <= 1'b1;
      crw_strobe <= push_ok;
    end
  end
endmodule

// File: rtl/fn_state_evq_chk.sv
module fn_state_evq_chk #(
  parameter int NFUNC = 4,
  parameter int Q_AW  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               rsp_valid,
  input logic               crw_strobe,
  input logic               evt_pending,
  input logic               evt_overflow,
  input logic [Q_AW:0]      q_cnt,
  input logic [NFUNC-1:0]   pres_q,
  input logic [NFUNC-1:0]   hen_q,
  input logic [NFUNC-1:0]   tmr_on,
  input logic [3*NFUNC-1:0] st_flat
);
  localparam logic [Q_AW:0] QFULL = (1 << Q_AW);

  AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid)); // R4
  AST_CRW_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    crw_strobe |-> evt_pending); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |=> evt_overflow); // R12
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QFULL); // R12

  for (genvar g = 0; g < NFUNC; g++) begin : g_fn
    AST_EN_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      hen_q[g] |-> (pres_q[g] && (st_flat[3*g +: 3] == 3'd3 || st_flat[3*g +: 3] == 3'd4))); // R3
    AST_TMR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_on[g] |-> (pres_q[g] && st_flat[3*g +: 3] != 3'd0 && st_flat[3*g +: 3] != 3'd1)); // R7
  end
endmodule

bind fn_state_evq fn_state_evq_chk #(.NFUNC(1 << SLOT_W), .Q_AW(Q_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rsp_valid(rsp_valid),
  .crw_strobe(crw_strobe), .evt_pending(evt_pending), .evt_overflow(evt_overflow),
  .q_cnt(q_cnt), .pres_q(pres_q), .hen_q(hen_q), .tmr_on(tmr_on), .st_flat(st_flat)
);

// File: tb/tb_fn_state_evq.sv
module tb_fn_state_evq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0; logic [1:0] cmd_op = 0; logic [7:0] cmd_fid = 0;
  logic rsp_valid; logic [2:0] rsp_code;
  logic plug_valid = 0; logic [1:0] plug_slot = 0; logic [7:0] plug_fid = 0; logic plug_attach = 0;
  logic unplug_valid = 0; logic [1:0] unplug_slot = 0;
  logic [15:0] rel_ticks = 16'd3; logic tmr_tick = 0;
  logic fault_valid = 0; logic [1:0] fault_slot = 0; logic [15:0] fault_code = 0;
  logic [31:0] fault_addr = 0, fault_info = 0;
  logic evt_pending, evt_pop = 0, evt_overflow, crw_strobe;
  logic [1:0] evt_type; logic [31:0] evt_handle, evt_addr, evt_extra;
  logic [7:0] evt_fid; logic [15:0] evt_status;

  int tests = 0, fails = 0;
  bit done = 0;

  fn_state_evq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] f, input logic [2:0] exp, input string tag);
    cmd_valid = 1; cmd_op = op; cmd_fid = f;
    step();
    cmd_valid = 0;
    chk(rsp_valid === 1'b1 && rsp_code === exp, tag, {rsp_valid, rsp_code}, {1'b1, exp});
  endtask

  task automatic do_plug(input logic [1:0] s, input logic [7:0] f, input logic att);
    plug_valid = 1; plug_slot = s; plug_fid = f; plug_attach = att;
    step();
    plug_valid = 0;
  endtask

  task automatic do_unplug(input logic [1:0] s);
    unplug_valid = 1; unplug_slot = s;
    step();
    unplug_valid = 0;
  endtask

  task automatic pop_chk(input logic [1:0] t, input logic [31:0] h, input logic [7:0] f,
                         input logic [15:0] st, input logic [31:0] a, input logic [31:0] x, input string tag);
    chk(evt_pending === 1'b1, {tag, " pending"}, evt_pending, 1);
    chk(evt_type === t && evt_handle === h, {tag, " type/handle"}, {evt_type, evt_handle}, {t, h});
    chk(evt_fid === f && evt_status === st, {tag, " fid/status"}, {evt_fid, evt_status}, {f, st});
    chk(evt_addr === a && evt_extra === x, {tag, " addr/extra"}, {evt_addr, evt_extra}, {a, x});
    evt_pop = 1; step(); evt_pop = 0;
  endtask

  task automatic chk_empty(input string tag);
    chk(evt_pending === 1'b0, tag, evt_pending, 0);
  endtask

  task automatic t_reset();
    chk(rsp_valid === 0 && crw_strobe === 0, "R14 rsp/crw after reset", {rsp_valid, crw_strobe}, 0);
    chk(evt_overflow === 0, "R14 overflow after reset", evt_overflow, 0);
    chk_empty("R14 queue empty after reset");
    do_cmd(2'd0, 8'h10, 3'd4, "R14 no function present");
    do_cmd(2'd1, 8'h77, 3'd4, "R2 deconfigure unknown");
    do_cmd(2'd2, 8'h77, 3'd4, "R3 enable unknown");
  endtask

  task automatic t_plug_states();
    do_plug(2'd0, 8'h10, 1'b0);
    chk(crw_strobe === 0, "R5 reserved plug no strobe", crw_strobe, 0);
    chk_empty("R5 reserved plug silent");
    do_cmd(2'd0, 8'h10, 3'd3, "R1 configure reserved");
    do_cmd(2'd1, 8'h10, 3'd3, "R2 deconfigure reserved");
    do_cmd(2'd2, 8'h10, 3'd3, "R3 enable reserved");
    do_plug(2'd0, 8'h10, 1'b1);
    chk(crw_strobe === 1, "R11 strobe on attach", crw_strobe, 1);
    pop_chk(2'd2, 32'h0, 8'h10, 16'h0301, 0, 0, "R5 R9 attach record");
    do_cmd(2'd1, 8'h10, 3'd2, "R2 deconfigure standby");
    do_cmd(2'd3, 8'h10, 3'd2, "R3 reset standby");
    do_cmd(2'd0, 8'h10, 3'd1, "R1 configure standby");
    do_cmd(2'd0, 8'h10, 3'd2, "R1 configure disabled");
    do_cmd(2'd2, 8'h10, 3'd1, "R3 enable disabled");
    do_cmd(2'd0, 8'h10, 3'd2, "R1 configure enabled");
    do_cmd(2'd2, 8'h10, 3'd2, "R3 enable enabled");
    step();
    chk(rsp_valid === 0, "R4 response one cycle", rsp_valid, 0);
  endtask

  task automatic t_fault_cancel();
    fault_valid = 1; fault_slot = 0; fault_code = 16'h0042;
    fault_addr = 32'h1234_5000; fault_info = 32'hA5;
    step(); fault_valid = 0;
    chk(crw_strobe === 1, "R11 strobe on error", crw_strobe, 1);
    pop_chk(2'd1, 32'h8000_0000, 8'h10, 16'h0042, 32'h1234_5000, 32'hA5, "R8 R9 error record");
    fault_valid = 1; step(); fault_valid = 0;
    chk_empty("R8 fault in error state ignored");
    do_cmd(2'd0, 8'h10, 3'd2, "R8 function left in error state");
    do_cmd(2'd3, 8'h10, 3'd1, "R3 reset from error");
    rel_ticks = 16'd3;
    do_unplug(2'd0);
    pop_chk(2'd2, 32'h0, 8'h10, 16'h0303, 0, 0, "R6 R3 detach request, enable bit clear");
    do_unplug(2'd0);
    chk_empty("R6 second unplug while timer runs");
    do_cmd(2'd1, 8'h10, 3'd1, "R2 deconfigure disabled");
    tmr_tick = 1;
    repeat (6) step();
    tmr_tick = 0;
    chk_empty("R2 timer cancelled by deconfigure");
    do_cmd(2'd1, 8'h10, 3'd2, "R2 function still in standby");
    do_unplug(2'd0);
    pop_chk(2'd2, 32'h0, 8'h10, 16'h0308, 0, 0, "R6 standby removal record");
    do_cmd(2'd0, 8'h10, 3'd4, "R6 removed function unknown");
    do_plug(2'd0, 8'h11, 1'b0);
    do_unplug(2'd0);
    chk_empty("R6 reserved removal silent");
    do_cmd(2'd0, 8'h11, 3'd4, "R6 reserved function removed");
  endtask

  task automatic t_timer();
    do_plug(2'd1, 8'h21, 1'b1);
    pop_chk(2'd2, 32'h1, 8'h21, 16'h0301, 0, 0, "R9 slot in handle");
    do_cmd(2'd0, 8'h21, 3'd1, "R1 configure slot1");
    rel_ticks = 16'd3;
    do_unplug(2'd1);
    pop_chk(2'd2, 32'h1, 8'h21, 16'h0303, 0, 0, "R6 detach request slot1");
    tmr_tick = 1;
    repeat (3) step();
    chk_empty("R7 no release before expiry");
    step();
    tmr_tick = 0;
    chk(crw_strobe === 1, "R7 strobe on forced release", crw_strobe, 1);
    pop_chk(2'd2, 32'h1, 8'h21, 16'h0304, 0, 0, "R7 forced release record");
    do_cmd(2'd0, 8'h21, 3'd4, "R7 function removed after expiry");
  endtask

  task automatic t_priority();
    do_plug(2'd2, 8'h30, 1'b1);
    pop_chk(2'd2, 32'h2, 8'h30, 16'h0301, 0, 0, "R5 attach slot2");
    do_plug(2'd3, 8'h30, 1'b1);
    chk_empty("R5 duplicate identifier ignored");
    cmd_valid = 1; cmd_op = 2'd0; cmd_fid = 8'h30;
    fault_valid = 1; fault_slot = 2'd2;
    step();
    cmd_valid = 0; fault_valid = 0;
    chk(rsp_valid === 0, "R13 command discarded under fault", rsp_valid, 0);
    chk_empty("R13 fault on standby ignored");
    do_cmd(2'd0, 8'h30, 3'd1, "R13 state untouched by discarded command");
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 9; k++) begin
      do_plug(2'd3, 8'h40, 1'b1);
      chk(crw_strobe === (2*k < 16), "R11 R12 strobe on attach push", crw_strobe, (2*k < 16));
      do_unplug(2'd3);
      chk(crw_strobe === (2*k+1 < 16), "R11 R12 strobe on removal push", crw_strobe, (2*k+1 < 16));
    end
    chk(evt_overflow === 1, "R12 overflow set", evt_overflow, 1);
    for (int k = 0; k < 16; k++)
      pop_chk(2'd2, 32'h3, 8'h40, (k % 2 == 0) ? 16'h0301 : 16'h0308, 0, 0, "R10 order after overflow");
    chk_empty("R10 queue drained");
    chk(evt_overflow === 1, "R12 overflow sticky", evt_overflow, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_plug_states();
    t_fault_cancel();
    t_timer();
    t_priority();
    t_overflow();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule